// File: doc/BRIEF.md
# SPI Transmit Queue and Request Controller

This block sits between a bus or DMA writer and the serial shift engine of a SPI port. Words pushed by the writer are held in a small first-in first-out buffer. The shift engine drains the buffer one word per request. The block watches how many entries are free and turns that into three signals: a level data request for the writer, a sticky urgent request, and a status interrupt condition. Each of these signals has its own programmable threshold.

When the shift engine asks for a word and the buffer holds none, the block still hands over a word. Depending on a policy input, that word is either zero or a repeat of the word sent before. The block also raises a sticky underrun flag. A transmit word counter, used only in master mode, can cap the number of words handed out. Once it reaches zero, requests from the shift engine are held off instead of underrunning. Writes that arrive while the buffer is full are discarded and set a sticky overflow flag.

Top module: `spi_txq_ctrl`

## Requirements
- R1: The buffer holds DEPTH (default 8) words of DATA_W (default 32) bits and returns them in write order. `level` gives the number of stored words, from 0 to DEPTH. In a cycle with both a write and a read, the read takes the oldest word present before that edge.
- R2: A write (`wr_valid`) while `level` equals DEPTH is discarded, even if a read happens in the same cycle, and sets `ovf_err`. `ovf_err` stays set until a cycle with `ovf_clr` high and no new overflow; a new overflow wins over the clear.
- R3: With E = DEPTH − level free entries, `reg_req` is high exactly when E is greater than a limit chosen by `cfg_regwm`. The limits are: code 0 → 0 (buffer not full), 1 → DEPTH/4, 2 → DEPTH/2, 3 → 3·DEPTH/4. `reg_req` is combinational from the present level.
- R4: `urg_req` is a register. If `cfg_urg_en` is low, it clears on the next edge. Otherwise, on an edge where E ≥ (`cfg_urgwm`+1)·DEPTH/4, it sets. Else, on an edge where `reg_req` is low, it clears. Otherwise it holds.
- R5: `stat_irq` is combinational from the present level and `cfg_stat_sel`. The codes are: 1 → E ≥ 1; 2 → E ≥ DEPTH/4; 3 → E ≥ DEPTH/2; 4 → E ≥ 3·DEPTH/4; 5 → E = DEPTH. Codes 0, 6 and 7 keep it low.
- R6: On an underrun (a granted request while `level` is 0) with `cfg_zero_fill` = 0, the word handed out is the previous `tx_word`. That value is zero after reset.
- R7: On an underrun with `cfg_zero_fill` = 1, the word handed out is all zeros. Any underrun sets `urun_err`. It clears only in a cycle with `urun_clr` high and no new underrun.
- R8: The counter is active when `cfg_master`, `cfg_wcnt_en` and `cfg_tx_en` are all high. While active and nonzero, each granted request lowers `wcnt` by one. A `wcnt_load` pulse writes `wcnt_val`, and this takes priority over the decrement.
- R9: While the counter is active and `wcnt` is zero, `tx_stall` is high. In that state `pop_req` is refused: no word is handed out, `tx_word` holds, the buffer is untouched, and no underrun is flagged.
- R10: With `cfg_master` low, `cfg_wcnt_en` has no effect. `wcnt` does not decrement and `tx_stall` stays low.
- R11: A granted `pop_req` sampled at a rising edge makes `tx_word` carry the handed-out word and `tx_vld` pulse high, both right after that edge.
- R12: After reset, `level`, `tx_word`, `tx_vld`, `wcnt`, `urg_req`, `urun_err` and `ovf_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write a word into the buffer |
| wr_data | input | DATA_W | Word to write |
| pop_req | input | 1 | Shift engine needs a word |
| cfg_master | input | 1 | 1 = master mode |
| cfg_tx_en | input | 1 | Transmit-initiate enable |
| cfg_wcnt_en | input | 1 | Word counter enable |
| wcnt_load | input | 1 | Load pulse for the word counter |
| wcnt_val | input | CNT_W | Word counter load value |
| cfg_zero_fill | input | 1 | Underrun policy: 0 = repeat last word, 1 = zeros |
| cfg_regwm | input | 2 | Regular request threshold code |
| cfg_urg_en | input | 1 | Urgent request enable |
| cfg_urgwm | input | 2 | Urgent request threshold code |
| cfg_stat_sel | input | 3 | Status interrupt condition code |
| ovf_clr | input | 1 | Clear pulse for `ovf_err` |
| urun_clr | input | 1 | Clear pulse for `urun_err` |
| tx_word | output | DATA_W | Word handed to the shift engine |
| tx_vld | output | 1 | One-cycle pulse: `tx_word` updated |
| tx_stall | output | 1 | Counter exhausted; requests refused |
| level | output | $clog2(DEPTH+1) | Stored word count |
| reg_req | output | 1 | Regular data request |
| urg_req | output | 1 | Latched urgent request |
| stat_irq | output | 1 | Status interrupt condition |
| urun_err | output | 1 | Sticky underrun flag |
| ovf_err | output | 1 | Sticky overflow flag |
| wcnt | output | CNT_W | Remaining word count |

## Verification
The hardest situation to reach is one where several conditions hold at once. The counter must be active and exhausted, the buffer must be empty, and a request must arrive, so that the stall correctly wins over the underrun. The urgent latch is hard too: it must be seen held across several levels between its set and release thresholds. The stimulus reaches these cases in two ways. Directed sequences load small counts and drain the buffer. Long random phases then vary the thresholds, the mode bits and the write/read densities every few hundred cycles, so the level sweeps across every threshold in both directions.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

    typedef enum logic [2:0] {
        STAT_OFF     = 3'd0,
        STAT_NOTFULL = 3'd1,
        STAT_QUARTER = 3'd2,
        STAT_HALF    = 3'd3,
        STAT_3QUART  = 3'd4,
        STAT_ALLFREE = 3'd5
    } stat_sel_e;

    // free-entry count that corresponds to a number of quarters of the buffer
    function automatic int unsigned quarter_of(input int unsigned depth,
                                               input int unsigned quarters);
        return (depth * quarters) / 4;
    endfunction

endpackage

// File: rtl/spi_txq_fifo.sv
module spi_txq_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [LVL_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == FULL_LVL);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rd_data = mem_q[st_q.rd];
    assign level   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + 1'b1;
        if (pop_ok)  st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr] <= push_data;
    end

endmodule

// File: rtl/spi_txq_wmark.sv
module spi_txq_wmark
    import spi_txq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       reg_sel,
    input  logic [1:0]       urg_sel,
    input  logic [2:0]       stat_sel,
    output logic             reg_req,
    output logic             urg_hit,
    output logic             stat_hit
);
    localparam logic [LVL_W-1:0] ALL_FREE = LVL_W'(DEPTH);

    logic [LVL_W-1:0] quarter [5];
    logic [LVL_W-1:0] free_cnt;
    logic [2:0]       urg_idx;

    for (genvar q = 0; q < 5; q++) begin : g_quarter
        assign quarter[q] = LVL_W'(quarter_of(DEPTH, q));
    end

    always_comb begin
        free_cnt = ALL_FREE - level;
        urg_idx  = {1'b0, urg_sel} + 3'd1;
        reg_req  = free_cnt > quarter[reg_sel];
        urg_hit  = free_cnt >= quarter[urg_idx];
        case (stat_sel_e'(stat_sel))
            STAT_NOTFULL: stat_hit = free_cnt != '0;
            STAT_QUARTER: stat_hit = free_cnt >= quarter[1];
            STAT_HALF:    stat_hit = free_cnt >= quarter[2];
            STAT_3QUART:  stat_hit = free_cnt >= quarter[3];
            STAT_ALLFREE: stat_hit = free_cnt == ALL_FREE;
            default:      stat_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_txq_wcnt.sv
module spi_txq_wcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wc_st_t;

    wc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)                       st_d.cnt = load_val;
        else if (dec && st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign zero = (st_q.cnt == '0);

endmodule

// File: rtl/spi_txq_ctrl.sv
module spi_txq_ctrl #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       pop_req,
    input  logic                       cfg_master,
    input  logic                       cfg_tx_en,
    input  logic                       cfg_wcnt_en,
    input  logic                       wcnt_load,
    input  logic [CNT_W-1:0]           wcnt_val,
    input  logic                       cfg_zero_fill,
    input  logic [1:0]                 cfg_regwm,
    input  logic                       cfg_urg_en,
    input  logic [1:0]                 cfg_urgwm,
    input  logic [2:0]                 cfg_stat_sel,
    input  logic                       ovf_clr,
    input  logic                       urun_clr,
    output logic [DATA_W-1:0]          tx_word,
    output logic                       tx_vld,
    output logic                       tx_stall,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       reg_req,
    output logic                       urg_req,
    output logic                       stat_irq,
    output logic                       urun_err,
    output logic                       ovf_err,
    output logic [CNT_W-1:0]           wcnt
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              vld;
        logic              urun;
        logic              ovf;
        logic              urg;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [DATA_W-1:0] head_word;
    logic              buf_empty, buf_full;
    logic              urg_hit;
    logic              wc_zero, wc_active, pop_go, underrun;

    spi_txq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data (wr_data),
        .pop       (pop_go),
        .rd_data   (head_word),
        .level     (level),
        .empty     (buf_empty),
        .full      (buf_full)
    );

    spi_txq_wmark #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_wmark (
        .level    (level),
        .reg_sel  (cfg_regwm),
        .urg_sel  (cfg_urgwm),
        .stat_sel (cfg_stat_sel),
        .reg_req  (reg_req),
        .urg_hit  (urg_hit),
        .stat_hit (stat_irq)
    );

    spi_txq_wcnt #(.CNT_W(CNT_W)) u_wcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wcnt_load),
        .load_val (wcnt_val),
        .dec      (wc_active && pop_go),
        .cnt      (wcnt),
        .zero     (wc_zero)
    );

    assign wc_active = cfg_master && cfg_wcnt_en && cfg_tx_en;
    assign tx_stall  = wc_active && wc_zero;
    assign pop_go    = pop_req && !tx_stall;
    assign underrun  = pop_go && buf_empty;

    always_comb begin
        st_d     = st_q;
        st_d.vld = pop_go;
        if (pop_go) begin
            if (!underrun)         st_d.word = head_word;
            else if (cfg_zero_fill) st_d.word = '0;
            else                    st_d.word = st_q.word;
        end
        st_d.urun = underrun || (st_q.urun && !urun_clr);
        st_d.ovf  = (wr_valid && buf_full) || (st_q.ovf && !ovf_clr);
        if (!cfg_urg_en)  st_d.urg = 1'b0;
        else if (urg_hit) st_d.urg = 1'b1;
        else if (!reg_req) st_d.urg = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_word  = st_q.word;
    assign tx_vld   = st_q.vld;
    assign urun_err = st_q.urun;
    assign ovf_err  = st_q.ovf;
    assign urg_req  = st_q.urg;

endmodule

// File: rtl/spi_txq_ctrl_chk.sv
module spi_txq_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_valid,
    input logic                       pop_req,
    input logic                       cfg_master,
    input logic                       wcnt_load,
    input logic                       cfg_zero_fill,
    input logic                       cfg_urg_en,
    input logic [2:0]                 cfg_stat_sel,
    input logic [DATA_W-1:0]          tx_word,
    input logic                       tx_vld,
    input logic                       tx_stall,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       urg_req,
    input logic                       stat_irq,
    input logic                       urun_err,
    input logic                       ovf_err,
    input logic [CNT_W-1:0]           wcnt
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    a_r2_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && level == FULL_LVL |=> ovf_err);

    a_r4_urg_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_urg_en |=> !urg_req);

    a_r5_stat_off: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stat_sel == 3'd0 |-> !stat_irq);

    a_r7_urun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !tx_stall && level == '0 |=> urun_err && tx_vld);

    a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !tx_stall && level == '0 && cfg_zero_fill |=> tx_word == '0);

    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && tx_stall |=> !tx_vld && $stable(tx_word));

    a_r10_slave_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> !tx_stall);

    a_r10_slave_no_dec: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master && !wcnt_load |=> $stable(wcnt));

endmodule

bind spi_txq_ctrl spi_txq_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .pop_req       (pop_req),
    .cfg_master    (cfg_master),
    .wcnt_load     (wcnt_load),
    .cfg_zero_fill (cfg_zero_fill),
    .cfg_urg_en    (cfg_urg_en),
    .cfg_stat_sel  (cfg_stat_sel),
    .tx_word       (tx_word),
    .tx_vld        (tx_vld),
    .tx_stall      (tx_stall),
    .level         (level),
    .urg_req       (urg_req),
    .stat_irq      (stat_irq),
    .urun_err      (urun_err),
    .ovf_err       (ovf_err),
    .wcnt          (wcnt)
);

// File: tb/test_spi_txq_ctrl.sv
`timescale 1ns/1ps
module test_spi_txq_ctrl;
    localparam int DW = 32;
    localparam int DP = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 0, pop_req = 0, cfg_master = 0, cfg_tx_en = 0, cfg_wcnt_en = 0;
    logic          wcnt_load = 0, cfg_zero_fill = 0, cfg_urg_en = 0, ovf_clr = 0, urun_clr = 0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] wcnt_val = '0;
    logic [1:0]    cfg_regwm = 0, cfg_urgwm = 0;
    logic [2:0]    cfg_stat_sel = 0;
    logic [DW-1:0] tx_word;
    logic          tx_vld, tx_stall, reg_req, urg_req, stat_irq, urun_err, ovf_err;
    logic [3:0]    level;
    logic [CW-1:0] wcnt;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [DW-1:0] mq[$];
    logic [DW-1:0] m_word;
    logic          m_vld, m_urun, m_ovf, m_urg;
    int            m_wcnt;

    always #10 clk = ~clk;

    spi_txq_ctrl #(.DATA_W(DW), .DEPTH(DP), .CNT_W(CW)) i_spi_txq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .pop_req(pop_req),
        .cfg_master(cfg_master), .cfg_tx_en(cfg_tx_en), .cfg_wcnt_en(cfg_wcnt_en),
        .wcnt_load(wcnt_load), .wcnt_val(wcnt_val), .cfg_zero_fill(cfg_zero_fill),
        .cfg_regwm(cfg_regwm), .cfg_urg_en(cfg_urg_en), .cfg_urgwm(cfg_urgwm),
        .cfg_stat_sel(cfg_stat_sel), .ovf_clr(ovf_clr), .urun_clr(urun_clr),
        .tx_word(tx_word), .tx_vld(tx_vld), .tx_stall(tx_stall), .level(level),
        .reg_req(reg_req), .urg_req(urg_req), .stat_irq(stat_irq),
        .urun_err(urun_err), .ovf_err(ovf_err), .wcnt(wcnt)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int free_n();
        return DP - mq.size();
    endfunction

    function automatic bit exp_reg();
        int lim [4] = '{0, 2, 4, 6};
        return free_n() > lim[cfg_regwm];
    endfunction

    function automatic bit exp_stat();
        case (cfg_stat_sel)
            3'd1: return free_n() >= 1;
            3'd2: return free_n() >= 2;
            3'd3: return free_n() >= 4;
            3'd4: return free_n() >= 6;
            3'd5: return free_n() == 8;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit exp_stall();
        return cfg_master && cfg_wcnt_en && cfg_tx_en && m_wcnt == 0;
    endfunction

    task automatic model_reset();
        mq.delete();
        m_word = '0; m_vld = 0; m_urun = 0; m_ovf = 0; m_urg = 0; m_wcnt = 0;
    endtask

    task automatic model_step();
        bit stall, grant, was_full, rq_pre, urg_set;
        int ulim [4] = '{2, 4, 6, 8};
        stall    = exp_stall();
        grant    = pop_req && !stall;
        was_full = (mq.size() == DP);
        rq_pre   = exp_reg();
        urg_set  = free_n() >= ulim[cfg_urgwm];
        // urgent latch
        if (!cfg_urg_en)  m_urg = 0;
        else if (urg_set) m_urg = 1;
        else if (!rq_pre) m_urg = 0;
        // sticky clears before new events so events win
        if (urun_clr) m_urun = 0;
        if (ovf_clr)  m_ovf = 0;
        m_vld = grant;
        if (grant) begin
            if (mq.size() != 0) m_word = mq.pop_front();
            else begin
                if (cfg_zero_fill) m_word = '0;
                m_urun = 1;
            end
            if (cfg_master && cfg_wcnt_en && cfg_tx_en && m_wcnt != 0) m_wcnt--;
        end
        if (wcnt_load) m_wcnt = int'(wcnt_val);
        if (wr_valid) begin
            if (was_full) m_ovf = 1;
            else          mq.push_back(wr_data);
        end
    endtask

    task automatic compare();
        chk(level == 4'(mq.size()), "R1 level", level, mq.size());
        chk(ovf_err == m_ovf, "R2 ovf_err", ovf_err, m_ovf);
        chk(reg_req == exp_reg(), "R3 reg_req", reg_req, exp_reg());
        chk(urg_req == m_urg, "R4 urg_req", urg_req, m_urg);
        chk(stat_irq == exp_stat(), "R5 stat_irq", stat_irq, exp_stat());
        chk(urun_err == m_urun, "R7 urun_err", urun_err, m_urun);
        chk(wcnt == CW'(m_wcnt), "R8 wcnt", wcnt, m_wcnt);
        chk(tx_stall == exp_stall(), "R9 tx_stall", tx_stall, exp_stall());
        chk(tx_word == m_word, "R11 tx_word", tx_word, m_word);
        chk(tx_vld == m_vld, "R11 tx_vld", tx_vld, m_vld);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_inputs();
        wr_valid = 0; pop_req = 0; wcnt_load = 0; ovf_clr = 0; urun_clr = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk(level == 0 && tx_word == 0 && tx_vld == 0 && wcnt == 0, "R12 reset data", level, 0);
        chk(!urg_req && !urun_err && !ovf_err, "R12 reset flags", {urg_req, urun_err, ovf_err}, 0);

        // R6: underrun with repeat policy right after reset gives zero
        pop_req = 1; cyc(); idle_inputs();
        chk(tx_word == 0 && urun_err, "R6 repeat after reset", tx_word, 0);
        urun_clr = 1; cyc(); idle_inputs();

        // fill past full: overflow
        for (int i = 0; i < DP + 2; i++) begin
            wr_valid = 1; wr_data = DW'(32'hA500_0000 + i); cyc();
        end
        idle_inputs();
        chk(ovf_err && level == 4'(DP), "R2 overflow", level, DP);

        // drain in order, then underrun repeats last word
        for (int i = 0; i < DP; i++) begin pop_req = 1; cyc(); end
        pop_req = 1; cyc(); idle_inputs();
        chk(tx_word == 32'hA500_0007, "R6 repeat last", tx_word, 32'hA500_0007);
        cfg_zero_fill = 1; pop_req = 1; cyc(); idle_inputs();
        chk(tx_word == 0, "R7 zero fill", tx_word, 0);
        ovf_clr = 1; urun_clr = 1; cyc(); idle_inputs();

        // R10: slave mode ignores counter enable
        cfg_master = 0; cfg_wcnt_en = 1; cfg_tx_en = 1;
        wcnt_load = 1; wcnt_val = 3; cyc(); idle_inputs();
        for (int i = 0; i < 4; i++) begin pop_req = 1; cyc(); end
        idle_inputs();
        chk(wcnt == 3 && !tx_stall, "R10 slave counter frozen", wcnt, 3);

        // R9: master, counter runs out, empty buffer, no underrun
        cfg_master = 1; urun_clr = 1; cyc(); idle_inputs();
        wcnt_load = 1; wcnt_val = 2; wr_valid = 1; wr_data = 32'h1234_5678; cyc(); idle_inputs();
        wr_valid = 1; wr_data = 32'h0BAD_F00D; cyc(); idle_inputs();
        for (int i = 0; i < 4; i++) begin pop_req = 1; cyc(); end
        idle_inputs();
        chk(wcnt == 0 && tx_stall && !urun_err, "R9 stall not underrun", urun_err, 0);
        chk(tx_word == 32'h0BAD_F00D, "R9 word held", tx_word, 32'h0BAD_F00D);

        // random phases
        for (int ph = 0; ph < 80; ph++) begin
            int wp, pp;
            cfg_regwm = 2'($urandom_range(0, 3));
            cfg_urgwm = 2'($urandom_range(0, 3));
            cfg_urg_en = 1'($urandom_range(0, 3) != 0);
            cfg_stat_sel = 3'($urandom_range(0, 7));
            cfg_zero_fill = 1'($urandom_range(0, 1));
            cfg_master = 1'($urandom_range(0, 3) != 0);
            cfg_wcnt_en = 1'($urandom_range(0, 1));
            cfg_tx_en = 1'($urandom_range(0, 3) != 0);
            wp = $urandom_range(10, 90);
            pp = $urandom_range(10, 90);
            for (int c = 0; c < 250; c++) begin
                wr_valid  = 1'($urandom_range(0, 99) < wp);
                wr_data   = DW'($urandom);
                pop_req   = 1'($urandom_range(0, 99) < pp);
                wcnt_load = 1'($urandom_range(0, 63) == 0);
                wcnt_val  = CW'($urandom_range(0, 12));
                ovf_clr   = 1'($urandom_range(0, 31) == 0);
                urun_clr  = 1'($urandom_range(0, 31) == 0);
                cyc();
            end
            idle_inputs();
        end
        finish_run();
    end
endmodule